// File: doc/BRIEF.md
# Interrupt Pending Priority Selector

This block decides, every cycle, whether a hart should take an interrupt and which cause number to take. It forms the set of interrupts that are both pending and enabled. It then gates that set by a global enable, which depends on the current privilege level and on whether each interrupt is delegated to supervisor level. Of what remains, the lowest-numbered interrupt wins.

While the hart runs a virtual guest, the selection takes two passes. The first pass looks only at the ordinary interrupts, gated by the hypervisor-level supervisor enable. If that pass finds anything, the winner must be handled by the hypervisor, and a force flag says so. Only when the first pass is empty are the virtual-supervisor interrupts (software, timer and external) considered. They go through the normal delegation gating.

The selection logic is combinational. A parameter can add one output register, which makes the result appear one clock edge after the inputs. The block has no data stream, so it has no valid/ready handshake. Every pin is a plain control or status level.

Top module: `irq_select_top`

## Requirements
- R1: The candidate set is pending AND enable. The virtual-supervisor interrupts sit at bit 2 (software), bit 6 (timer) and bit 10 (external). They are removed from the ordinary set, and when virtualization is off they can never be selected.
- R2: Interrupts that are not delegated are globally enabled when the privilege is below machine (user=0, supervisor=1, code 2 also counts as below), or when the privilege is machine (3) and the machine enable bit is 1.
- R3: Delegated interrupts are globally enabled when the privilege is user, or when the privilege is supervisor and the supervisor enable bit is 1. At privilege 2 or 3 they are blocked.
- R4: A candidate bit i is routed by delegation bit i. If delegation bit i is 0 the bit follows the R2 enable, and if it is 1 the bit follows the R3 enable.
- R5: Among the surviving bits, the lowest index wins. The cause output is that index in binary.
- R6: With virtualization on, ordinary candidates are first gated only by the hypervisor supervisor enable (open at user, or at supervisor with hs_sie=1), and delegation plays no part. If any survive, the lowest one is selected and force_hs_o is 1.
- R7: With virtualization on and the R6 pass empty, only the virtual-supervisor candidates go through R2 to R5, and force_hs_o is 0.
- R8: When nothing survives, irq_valid_o is 0, irq_cause_o is 0 and force_hs_o is 0.
- R9: With the output register on (the default), outputs show the result for the inputs present at the previous rising edge. Reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pend_i | input | 16 | Pending interrupt vector |
| irq_en_i | input | 16 | Interrupt enable vector |
| deleg_i | input | 16 | Delegation mask (1 = supervisor handles it) |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| mie_i | input | 1 | Machine global enable |
| sie_i | input | 1 | Supervisor global enable |
| virt_i | input | 1 | Virtualization active |
| hs_sie_i | input | 1 | Hypervisor-level supervisor enable |
| irq_valid_o | output | 1 | An interrupt should be taken |
| irq_cause_o | output | 4 | Selected cause number |
| force_hs_o | output | 1 | Selected interrupt must trap to the hypervisor |

## Verification
The hypervisor pass and the virtual-supervisor pass can both have candidates in the same cycle. The correct outcome is then that the ordinary winner takes priority and the force flag is set, even when a virtual-supervisor bit has a lower index. The bench provokes this by sweeping all combinations of privilege, the three enable bits and the virtualization flag, each against a set of pending, enable and delegation patterns. Some patterns light both sets at once, and some put a virtual-supervisor bit below the lowest ordinary bit. Each result is judged against cause, valid and force values that the bench computes from the requirement rules.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;
endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_sel_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       mie_i,
  input  logic       sie_i,
  input  logic       hs_sie_i,
  output logic       m_on_o,
  output logic       s_on_o,
  output logic       hs_on_o
);
  always_comb begin
    m_on_o  = (priv_i < PRIV_M) || ((priv_i == PRIV_M) && mie_i);
    s_on_o  = (priv_i < PRIV_S) || ((priv_i == PRIV_S) && sie_i);
    hs_on_o = (priv_i < PRIV_S) || ((priv_i == PRIV_S) && hs_sie_i);
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N       = 16,
  parameter int CAUSE_W = $clog2(N)
) (
  input  logic [N-1:0]       req_i,
  output logic               hit_o,
  output logic [CAUSE_W-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        idx_o = CAUSE_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int           N       = 16,
  parameter int           CAUSE_W = $clog2(N),
  parameter logic [N-1:0] VS_MASK = 16'h0444
) (
  input  logic [N-1:0]       pend_i,
  input  logic [N-1:0]       en_i,
  input  logic [N-1:0]       deleg_i,
  input  logic               virt_i,
  input  logic               m_on_i,
  input  logic               s_on_i,
  input  logic               hs_on_i,
  output logic               valid_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               force_o
);
  logic [N-1:0]       live, cand, vcand, hs_req, base, fin_req;
  logic               hs_hit, fin_hit;
  logic [CAUSE_W-1:0] hs_idx, fin_idx;

  always_comb begin
    live    = pend_i & en_i;
    cand    = live & ~VS_MASK;
    vcand   = live & VS_MASK;
    hs_req  = (virt_i && hs_on_i) ? cand : '0;
    base    = virt_i ? vcand : cand;
    fin_req = (base & ~deleg_i & {N{m_on_i}}) |
              (base &  deleg_i & {N{s_on_i}});
  end

  irq_pick #(.N(N), .CAUSE_W(CAUSE_W)) u_pick_hs (
    .req_i(hs_req), .hit_o(hs_hit), .idx_o(hs_idx)
  );

  irq_pick #(.N(N), .CAUSE_W(CAUSE_W)) u_pick_fin (
    .req_i(fin_req), .hit_o(fin_hit), .idx_o(fin_idx)
  );

  always_comb begin
    force_o = hs_hit;
    valid_o = hs_hit | fin_hit;
    cause_o = hs_hit ? hs_idx : fin_idx;
  end
endmodule

// File: rtl/irq_select_top.sv
module irq_select_top #(
  parameter int           N       = 16,
  parameter int           CAUSE_W = $clog2(N),
  parameter logic [N-1:0] VS_MASK = 16'h0444,
  parameter bit           REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       irq_pend_i,
  input  logic [N-1:0]       irq_en_i,
  input  logic [N-1:0]       deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               mie_i,
  input  logic               sie_i,
  input  logic               virt_i,
  input  logic               hs_sie_i,
  output logic               irq_valid_o,
  output logic [CAUSE_W-1:0] irq_cause_o,
  output logic               force_hs_o
);
  logic               m_on, s_on, hs_on;
  logic               valid_c, force_c;
  logic [CAUSE_W-1:0] cause_c;

  irq_gate u_gate (
    .priv_i(priv_i), .mie_i(mie_i), .sie_i(sie_i), .hs_sie_i(hs_sie_i),
    .m_on_o(m_on), .s_on_o(s_on), .hs_on_o(hs_on)
  );

  irq_route #(.N(N), .CAUSE_W(CAUSE_W), .VS_MASK(VS_MASK)) u_route (
    .pend_i(irq_pend_i), .en_i(irq_en_i), .deleg_i(deleg_i),
    .virt_i(virt_i), .m_on_i(m_on), .s_on_i(s_on), .hs_on_i(hs_on),
    .valid_o(valid_c), .cause_o(cause_c), .force_o(force_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          irq_valid_o <= 1'b0;
          irq_cause_o <= '0;
          force_hs_o  <= 1'b0;
        end else begin
          irq_valid_o <= valid_c;
          irq_cause_o <= cause_c;
          force_hs_o  <= force_c;
        end
      end
    end else begin : g_comb
      always_comb begin
        irq_valid_o = valid_c;
        irq_cause_o = cause_c;
        force_hs_o  = force_c;
      end
    end
  endgenerate

  // R5
  valid_is_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_c |-> (irq_pend_i[cause_c] && irq_en_i[cause_c]));
  // R6
  force_needs_virt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_c |-> (virt_i && valid_c));
  // R6
  force_not_vs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_c |-> !VS_MASK[cause_c]);
  // R1
  vs_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_c && !virt_i) |-> !VS_MASK[cause_c]);
  // R8
  idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_c |-> (cause_c == '0 && !force_c));
  // R3
  deleg_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_c && !force_c && priv_i[1]) |-> !deleg_i[cause_c]);
endmodule

// File: tb/sim_irq_select_top.sv
module sim_irq_select_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pend = '0, en = '0, dlg = '0;
  logic [1:0]  priv = '0;
  logic        mie = 0, sie = 0, virt = 0, hsie = 0;
  logic        v_o, f_o;
  logic [3:0]  c_o;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  irq_select_top u0 (
    .clk(clk), .rst_n(rst_n), .irq_pend_i(pend), .irq_en_i(en),
    .deleg_i(dlg), .priv_i(priv), .mie_i(mie), .sie_i(sie),
    .virt_i(virt), .hs_sie_i(hsie), .irq_valid_o(v_o),
    .irq_cause_o(c_o), .force_hs_o(f_o)
  );

  function automatic void lowest(input logic [15:0] s, output bit h, output logic [3:0] k);
    h = 0; k = 0;
    for (int i = 15; i >= 0; i--) if (s[i]) begin h = 1; k = 4'(i); end
  endfunction

  task automatic expect_now(input string tag);
    logic [15:0] vs, live, setn, fin;
    bit mon, son, hon, h1, h2, ev, ef;
    logic [3:0] k1, k2, ec;
    vs   = 16'h0444;                       // R1 bits 2, 6, 10
    live = pend & en;
    mon  = (priv != 2'd3) || mie;          // R2
    son  = (priv == 2'd0) || (priv == 2'd1 && sie);  // R3
    hon  = (priv == 2'd0) || (priv == 2'd1 && hsie); // R6
    lowest((virt && hon) ? (live & ~vs) : 16'h0, h1, k1);
    setn = virt ? (live & vs) : (live & ~vs);
    fin  = (setn & ~dlg & {16{mon}}) | (setn & dlg & {16{son}}); // R4
    lowest(fin, h2, k2);                   // R5
    ev = h1 | h2; ef = h1; ec = h1 ? k1 : k2; // R6 R7 R8
    @(negedge clk);                        // R9 one register
    checks++;
    if (v_o !== ev || c_o !== ec || f_o !== ef) begin
      errors++;
      $display("FAIL %s: got v%0b c%0d f%0b expected v%0b c%0d f%0b",
               tag, v_o, c_o, f_o, ev, ec, ef);
    end
  endtask

  task automatic drive(input logic [15:0] p, e, d);
    pend = p; en = e; dlg = d;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] x;
    pend = 16'hFFFF; en = 16'hFFFF; priv = 2'd0;
    repeat (3) @(negedge clk);
    checks++;                              // R9 reset state
    if (v_o !== 0 || c_o !== 0 || f_o !== 0) begin
      errors++;
      $display("FAIL R9 reset: got v%0b c%0d f%0b expected 0 0 0", v_o, c_o, f_o);
    end
    rst_n = 1'b1;

    // R6 with R7: VS bit 2 lower than ordinary bit 5, both live
    virt = 1; priv = 2'd0; drive(16'h0024, 16'hFFFF, 16'h0000); expect_now("R6 both sets");
    // R7: only VS bits, delegated at supervisor with sie
    priv = 2'd1; sie = 1; hsie = 0; drive(16'h0444, 16'h0440, 16'h0440); expect_now("R7 vs pass");
    // R1: virt off, only VS bits pending
    virt = 0; priv = 2'd0; drive(16'h0444, 16'hFFFF, 16'h0); expect_now("R1 vs ignored");
    // R8: nothing enabled
    drive(16'hFFFF, 16'h0000, 16'h0); expect_now("R8 empty");
    // R3: delegated at machine is blocked, undelegated bit 15 wins
    priv = 2'd3; mie = 1; drive(16'h8001, 16'hFFFF, 16'h0001); expect_now("R3 R4 routing");
    // R2: machine with mie clear
    mie = 0; drive(16'h8001, 16'hFFFF, 16'h0000); expect_now("R2 mie off");
    // R5: lowest index
    priv = 2'd1; drive(16'hF0F0, 16'hFF30, 16'h0); expect_now("R5 lowest");

    // near-exhaustive sweep
    x = 16'hACE1;
    for (int c = 0; c < 64; c++) begin
      priv = c[1:0]; mie = c[2]; sie = c[3]; virt = c[4]; hsie = c[5];
      for (int n = 0; n < 24; n++) begin
        logic [15:0] a, b, d;
        x = x ^ (x << 7); x = x ^ (x >> 9); x = x ^ (x << 8); a = x;
        x = x ^ (x << 7); x = x ^ (x >> 9); x = x ^ (x << 8); b = x;
        x = x ^ (x << 7); x = x ^ (x >> 9); x = x ^ (x << 8); d = x;
        if (n % 4 == 1) a = a & 16'h0444 | (a & 16'h8000);
        if (n % 4 == 2) a = a & (a - 16'h1) & 16'hFF44;
        drive(a, b | 16'h0444, d);
        expect_now("R2 R3 R4 R5 R6 R7 sweep");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule